// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave with Write Protection

This block is a mode-0 SPI slave placed in front of a byte-wide register memory. A bus master frames each command with an active-low chip select, clocks bits in on the rising edge of the serial clock and reads data back on the output line. The opcodes the block accepts are write-enable, status read, status write, memory write and memory read. Memory accesses send a three-byte address, most significant bit first. Only the low `AW` bits of that address are used. A write burst stores each byte the moment its eighth bit arrives. There is no page buffer, so a burst may run for any length, and its address wraps from the top of the array back to zero.

An internal write-enable latch gates every write to the status register and to the array. A status register holds a protect-enable flag and a two-bit protect level. The protect level fences off a top portion of the array. When a burst reaches that fence, its address freezes and the burst writes nothing more. The write-protect pin can lock only the status register. It never blocks the array. All serial inputs are oversampled by the system clock, so the whole block runs in a single clock domain.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is 0. After reset the status byte reads 0x00.
- R2: Opcode 0x05 returns the status byte MSB first, repeated for as long as clocks continue. The layout is: bit 7 protect-enable, bits 3:2 protect level, bit 1 write-enable latch, all other bits 0. `so_oe` stays 0 until the eighth opcode bit has been taken.
- R3: Opcode 0x06 sets the write-enable latch.
- R4: Opcode 0x01 followed by one data byte loads protect-enable from bit 7 and the protect level from bits 3:2, then clears the latch. This happens only if the latch was already set. Otherwise the status register is left unchanged.
- R5: A status write is refused when protect-enable is 1 and `wp_n` is low. A refused write leaves both the status register and the latch unchanged.
- R6: Opcode 0x02, followed by three address bytes, writes each later data byte to consecutive addresses, but only if the latch was set before the opcode. The latch is cleared when chip select rises after such a write.
- R7: Opcode 0x03, followed by three address bytes, returns the bytes at consecutive addresses, MSB first.
- R8: The address after 2^AW−1 is 0, for both writes and reads.
- R9: If chip select rises before the eighth bit of a data byte, that partial byte is not written.
- R10: A burst that reaches a protected address stores nothing at that address or after it, for the rest of that chip-select frame.
- R11: The protect level selects the protected region: 00 protects nothing, 01 protects the top quarter of the array, 10 protects the top half, and 11 protects the whole array.
- R12: `wp_n` has no effect on array writes.
- R13: An unknown opcode is ignored until chip select rises. `so_oe` stays 0 and the status register is unchanged.
- R14: Address bits at and above bit `AW` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select framing each command |
| sck | input | 1 | Serial clock from the master (mode 0) |
| si | input | 1 | Serial data from master to slave |
| wp_n | input | 1 | Active-low write protect for the status register |
| so | output | 1 | Serial data from slave to master |
| so_oe | output | 1 | Drive enable for `so`; 0 means high impedance |

## Verification
The bench builds the block with `AW = 6`, which gives a 64-byte array, and with two synchronizer stages. At that size the address wrap from 63 to 0 and the quarter and half protection fences at 48 and 32 can all be reached with bursts of a few bytes. The small width also makes it easy to send addresses with high-order bits set, which shows that those bits are ignored. A table-driven pass steps the status register through every combination of latch state, pin level and protect-enable. Directed bursts then check partial bytes, the freeze at a fence, and the link between the latch and chip select.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OPC_SR_STORE = 8'h01;
    localparam logic [7:0] OPC_ARR_PUT  = 8'h02;
    localparam logic [7:0] OPC_ARR_GET  = 8'h03;
    localparam logic [7:0] OPC_SR_FETCH = 8'h05;
    localparam logic [7:0] OPC_ARM      = 8'h06;

    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_SROUT = 3'd4,
        ST_SRIN  = 3'd5,
        ST_SKIP  = 3'd6
    } phase_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic cs_act,
    output logic sck_rise,
    output logic si_s,
    output logic wp_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_q, sck_q, si_q, wp_q;
    logic         sck_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q       <= '1;
            sck_q      <= '0;
            si_q       <= '0;
            wp_q       <= '1;
            sck_last_q <= 1'b0;
        end else begin
            cs_q       <= {cs_q[TOP-1:0], cs_n};
            sck_q      <= {sck_q[TOP-1:0], sck};
            si_q       <= {si_q[TOP-1:0], si};
            wp_q       <= {wp_q[TOP-1:0], wp_n};
            sck_last_q <= sck_q[TOP];
        end
    end

    assign cs_act   = ~cs_q[TOP];
    assign sck_rise = sck_q[TOP] & ~sck_last_q & ~cs_q[TOP];
    assign si_s     = si_q[TOP];
    assign wp_s     = wp_q[TOP];

endmodule

// File: rtl/spi_mem_guard.sv
module spi_mem_guard #(
    parameter int AW = 10
) (
    input  logic [1:0]    level,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    always_comb begin
        unique case (level)
            2'b00:   hit = 1'b0;
            2'b01:   hit = &addr[AW-1 -: 2];
            2'b10:   hit = addr[AW-1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= 8'h00;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int AW     = 10,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    typedef struct packed {
        phase_e        st;
        logic [2:0]    bcnt;
        logic [6:0]    rx;
        logic [1:0]    acnt;
        logic [AW-1:0] addr;
        logic [7:0]    tx;
        logic          oe;
        logic          is_wr;
        logic          frozen;
        logic          wel;
        logic          wpen;
        logic [1:0]    bp;
    } regs_t;

    regs_t q, d;

    logic          cs_act, sck_rise, si_s, wp_s;
    logic          prot_hit, mem_we, sr_we;
    logic [AW-1:0] nxt_addr;
    logic [7:0]    rd_data, byte_in, status;

    spi_mem_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
        .cs_act(cs_act), .sck_rise(sck_rise), .si_s(si_s), .wp_s(wp_s)
    );

    spi_mem_guard #(.AW(AW)) u_guard (
        .level(q.bp), .addr(q.addr), .hit(prot_hit)
    );

    spi_mem_store #(.AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(q.addr), .wdata(byte_in),
        .raddr(nxt_addr), .rdata(rd_data)
    );

    // Address fetched next: the shifted-in address at the end of the
    // address phase, otherwise the successor of the current address.
    assign nxt_addr = (q.st == ST_ADDR) ? {q.addr[AW-2:0], si_s} : q.addr + 1'b1;
    assign byte_in  = {q.rx, si_s};
    assign status   = {q.wpen, 3'b000, q.bp, q.wel, 1'b0};

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        sr_we  = 1'b0;
        if (!cs_act) begin
            d.st     = ST_OPC;
            d.bcnt   = '0;
            d.acnt   = '0;
            d.oe     = 1'b0;
            d.frozen = 1'b0;
            d.is_wr  = 1'b0;
            if (q.is_wr) d.wel = 1'b0;
        end else if (sck_rise) begin
            d.bcnt = q.bcnt + 3'd1;
            d.rx   = {q.rx[5:0], si_s};
            d.tx   = {q.tx[6:0], 1'b0};
            if (q.st == ST_ADDR) d.addr = nxt_addr;
            if (q.bcnt == 3'd7) begin
                unique case (q.st)
                    ST_OPC: begin
                        unique case (byte_in)
                            OPC_ARM: begin
                                d.wel = 1'b1;
                                d.st  = ST_SKIP;
                            end
                            OPC_SR_FETCH: begin
                                d.st = ST_SROUT;
                                d.tx = status;
                                d.oe = 1'b1;
                            end
                            OPC_SR_STORE: d.st = ST_SRIN;
                            OPC_ARR_PUT: begin
                                d.st    = q.wel ? ST_ADDR : ST_SKIP;
                                d.is_wr = q.wel;
                            end
                            OPC_ARR_GET: d.st = ST_ADDR;
                            default:     d.st = ST_SKIP;
                        endcase
                    end
                    ST_ADDR: begin
                        d.acnt = q.acnt + 2'd1;
                        if (q.acnt == 2'd2) begin
                            if (q.is_wr) begin
                                d.st = ST_WDATA;
                            end else begin
                                d.st = ST_RDATA;
                                d.tx = rd_data;
                                d.oe = 1'b1;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (!q.frozen) begin
                            if (prot_hit) begin
                                d.frozen = 1'b1;
                            end else begin
                                mem_we = 1'b1;
                                d.addr = nxt_addr;
                            end
                        end
                    end
                    ST_RDATA: begin
                        d.addr = nxt_addr;
                        d.tx   = rd_data;
                    end
                    ST_SROUT: d.tx = status;
                    ST_SRIN: begin
                        if (q.wel && !(q.wpen && !wp_s)) begin
                            sr_we  = 1'b1;
                            d.wpen = byte_in[7];
                            d.bp   = byte_in[3:2];
                            d.wel  = 1'b0;
                        end
                        d.st = ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign so    = q.tx[7];
    assign so_oe = q.oe;

    // R1: output driver released once the frame ends
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_oe);
    // R13: driver only on in the two output phases
    p_out_phase_r13: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (q.st == ST_SROUT || q.st == ST_RDATA));
    // R4: accepted status write drops the latch
    p_latch_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> !q.wel);
    // R5: no status write while pin holds a locked register
    p_sr_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> !(q.wpen && !wp_s));
    // R6: array writes need the latch
    p_arr_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> q.wel);
    // R10: no write lands in a fenced address, frozen bursts keep their address
    p_arr_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!prot_hit && !q.frozen));
    p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.frozen |=> (!q.frozen || $stable(q.addr)));

endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so, so_oe;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    spi_mem_slave #(.AW(AW), .STAGES(2)) u_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    // {wp_n, send_wren, status byte written, status expected after}
    localparam logic [17:0] SR_VEC [8] = '{
        {1'b1, 1'b1, 8'h8C, 8'h8C},
        {1'b0, 1'b1, 8'h00, 8'h8E},
        {1'b1, 1'b0, 8'h04, 8'h04},
        {1'b1, 1'b0, 8'h08, 8'h04},
        {1'b0, 1'b1, 8'h73, 8'h00},
        {1'b1, 1'b1, 8'hFF, 8'h8C},
        {1'b0, 1'b1, 8'h88, 8'h8E},
        {1'b1, 1'b0, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r);
        @(negedge clk) si = b;
        repeat (4) @(negedge clk);
        r = so;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            sbit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); xfer(op, r); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xfer(8'h05, r); xfer(8'h00, v); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xfer(8'h01, r); xfer(v, r); cs_hi();
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    endtask

    task automatic wr(input logic [23:0] a, input int n, input logic [31:0] bytes);
        logic [7:0] r;
        cs_lo(); xfer(8'h02, r); send_addr(a);
        for (int k = 0; k < n; k++) xfer(bytes[31-8*k -: 8], r);
        cs_hi();
    endtask

    task automatic rd(input logic [23:0] a, output logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xfer(8'h03, r); send_addr(a); xfer(8'h00, v); cs_hi();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hang exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, r, b0, b1, b2;
        logic bt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 so_oe after reset", {7'd0, so_oe}, 8'h00);
        rdsr(v); chk("R1 status after reset", v, 8'h00);

        // R2: driver stays off through the opcode, status repeats
        cs_lo();
        for (int i = 7; i >= 1; i--) sbit(bit'(8'h05 >> i), bt);
        chk("R2 so_oe during opcode", {7'd0, so_oe}, 8'h00);
        sbit(1'b1, bt);
        chk("R2 so_oe after opcode", {7'd0, so_oe}, 8'h01);
        xfer(8'h00, v); chk("R2 status byte", v, 8'h00);
        cs_hi();

        // R4, R5: status write table
        foreach (SR_VEC[i]) begin
            wp_n = SR_VEC[i][17];
            if (SR_VEC[i][16]) cmd1(8'h06);
            wrsr(SR_VEC[i][15:8]);
            rdsr(v);
            chk($sformatf("R4/R5 vector %0d", i), v, SR_VEC[i][7:0]);
        end
        wp_n = 1'b1;

        // R3 and R2 repeated status
        cmd1(8'h06);
        cs_lo(); xfer(8'h05, r); xfer(8'h00, b0); xfer(8'h00, b1); cs_hi();
        chk("R3 latch set", b0, 8'h02);
        chk("R2 status repeats", b1, 8'h02);

        // R6 / R7: burst write and burst read, latch cleared after
        wr(24'd10, 3, 32'h11223300);
        cs_lo(); xfer(8'h03, r); send_addr(24'd10);
        xfer(8'h00, b0); xfer(8'h00, b1); xfer(8'h00, b2); cs_hi();
        chk("R7 read 10", b0, 8'h11);
        chk("R7 read 11", b1, 8'h22);
        chk("R7 read 12", b2, 8'h33);
        rdsr(v); chk("R6 latch cleared", v, 8'h00);

        // R6: write without latch ignored
        wr(24'd5, 1, 32'hAA000000);
        rd(24'd5, v); chk("R6 no latch no write", v, 8'h00);

        // R8: wrap at the top for write and read
        cmd1(8'h06);
        wr(24'd62, 3, 32'hA1A2A300);
        cs_lo(); xfer(8'h03, r); send_addr(24'd62);
        xfer(8'h00, b0); xfer(8'h00, b1); xfer(8'h00, b2); cs_hi();
        chk("R8 read 62", b0, 8'hA1);
        chk("R8 read 63", b1, 8'hA2);
        chk("R8 wrapped read 0", b2, 8'hA3);

        // R14: upper address bits ignored
        cmd1(8'h06);
        wr(24'h010005, 1, 32'h5C000000);
        rd(24'hFFFFC5, v); chk("R14 high bits ignored", v, 8'h5C);

        // R9: partial byte dropped
        cmd1(8'h06);
        cs_lo(); xfer(8'h02, r); send_addr(24'd20); xfer(8'h5A, r);
        for (int i = 0; i < 4; i++) sbit(1'b1, bt);
        cs_hi();
        rd(24'd20, v); chk("R9 full byte kept", v, 8'h5A);
        rd(24'd21, v); chk("R9 partial byte dropped", v, 8'h00);

        // R12: pin low does not block array
        wp_n = 1'b0;
        cmd1(8'h06);
        wr(24'd30, 1, 32'h77000000);
        rd(24'd30, v); chk("R12 write with pin low", v, 8'h77);
        wp_n = 1'b1;

        // R11 / R10: top quarter fence at 48
        cmd1(8'h06); wrsr(8'h04);
        cmd1(8'h06);
        wr(24'd46, 4, 32'h01020304);
        rd(24'd46, v); chk("R10 before fence 46", v, 8'h01);
        rd(24'd47, v); chk("R10 before fence 47", v, 8'h02);
        rd(24'd48, v); chk("R10 fence 48 untouched", v, 8'h00);
        rd(24'd49, v); chk("R10 after freeze 49", v, 8'h00);
        cmd1(8'h06);
        wr(24'd62, 1, 32'hFF000000);
        rd(24'd62, v); chk("R11 quarter protects 62", v, 8'hA1);

        // R11: half fence at 32
        cmd1(8'h06); wrsr(8'h08);
        cmd1(8'h06); wr(24'd33, 1, 32'h99000000);
        rd(24'd33, v); chk("R11 half protects 33", v, 8'h00);
        cmd1(8'h06); wr(24'd31, 1, 32'h44000000);
        rd(24'd31, v); chk("R11 half leaves 31", v, 8'h44);

        // R11: whole array
        cmd1(8'h06); wrsr(8'h0C);
        cmd1(8'h06); wr(24'd0, 1, 32'h55000000);
        rd(24'd0, v); chk("R11 all protects 0", v, 8'hA3);
        rdsr(v); chk("R6 latch cleared after frozen burst", v, 8'h0C);

        // R13: unknown opcode ignored
        cmd1(8'h06);
        cs_lo(); xfer(8'hAB, r); xfer(8'h00, r);
        chk("R13 so_oe stays low", {7'd0, so_oe}, 8'h00);
        xfer(8'h00, r); cs_hi();
        rdsr(v); chk("R13 status unchanged", v, 8'h0E);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule